// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block moves a microcontroller between normal operation and three stop modes of different depth. Stop1 is the deepest: every power domain is switched off and the I/O pins are forced to their reset state. Stop2 keeps only the RAM in standby. Stop3 is the lightest: most domains stay in standby, and the ADC and the clock generator stay powered if their own enable bits say so. The CPU asks for a stop with a one-cycle strobe. The mode-select field and the stop-enable bit, sampled on that strobe, choose the mode.

In any stop mode, wake comes from an active-low wake pin or from the periodic real-time interrupt, but only when that interrupt is enabled. Waking from stop2 or stop3 returns straight to run. Waking from stop1 works like a power-on start: the system reset output is held for a fixed number of cycles, and for longer while the supply-low input is asserted. A sticky powered-down flag is set on that wake. Only a true power-on reset or a software write of 1 to the acknowledge bit clears it. Software reads the flag to tell a stop1 recovery from a cold start.

States: `ST_RUN`, `ST_STOP1`, `ST_STOP2`, `ST_STOP3`, `ST_RSTHOLD`. Transitions:
- **por_release**: `ST_RSTHOLD` → `ST_RUN`.
- **enter_stop**: `ST_RUN` → `ST_STOPx`, on a legal request.
- **illegal_stop**: `ST_RUN` → `ST_RSTHOLD`, on an illegal request with `ILLEGAL_RESET` set.
- **deep_wake**: `ST_STOP1` → `ST_RSTHOLD`.
- **light_wake**: `ST_STOP2`/`ST_STOP3` → `ST_RUN`.
- **supply_hold**: `ST_RSTHOLD` → `ST_RSTHOLD`, while the supply is low.

Top module: `lpstop_ctrl`

## Requirements
- R1: After `rst_n` is released, `sys_rst` stays high for RST_CYCLES (default 4) clock edges with `vdd_low` = 0. The block then enters run. In run, `pwr_on` = 8'hFF, `stby` = 0, `periph_clk_en` = 1 and `stat_rd` = 0.
- R2: A `stop_req` in run with `stop_en` = 1 enters the mode given by `mode_sel` at the next edge (01 = stop1, 10 = stop2, 11 = stop3), and `in_stop` goes high. A `stop_req` while already stopped is ignored.
- R3: A `stop_req` with `stop_en` = 0 or `mode_sel` = 00 enters the reset-hold state when ILLEGAL_RESET = 1 (default). It then behaves as in R1 and leaves `stat_rd` unchanged. With ILLEGAL_RESET = 0 such a request is ignored.
- R4: The domain bit order is 0 CPU, 1 RAM, 2 flash, 3 port registers, 4 ADC, 5 comparator, 6 clock generator, 7 serial bus.
  - In stop1 `pwr_on` and `stby` are both 0.
  - In stop2 `pwr_on` = 0 and `stby` = 8'h02.
  - In stop3 `stby` = 8'hAF, bit 4 of `pwr_on` = `adc_stop_on`, bit 6 of `pwr_on` = `clkgen_stop_on`, and the other bits of `pwr_on` are 0.
- R5: In every stop mode `periph_clk_en` = 0 and `dbg_clk_en` follows `dbg_en`. Outside stop both are 1.
- R6: `io_force_rst` is 1 in stop1 and in reset hold, and 0 in run, stop2 and stop3.
- R7: `wake_pin_n` is active low and passes through a two-flop synchroniser. A low level seen at clock edge k makes the block leave stop at edge k+2, even if the low lasts one cycle, and a pin already low wakes the block as soon as it stops. While stopped, `wake_pullup` = `wake_pu_en`. Outside stop it is 0.
- R8: `rti_wake` wakes any stop mode at the next edge when `rti_en` = 1. When `rti_en` = 0 it has no effect.
- R9: Waking from stop1 enters reset hold (`sys_rst` = 1). Reset hold lasts RST_CYCLES edges counted after the last edge with `vdd_low` = 1, then the block returns to run.
- R10: Waking from stop2 or stop3 returns to run at the next edge, with no `sys_rst` pulse and no change to `stat_rd`.
- R11: Bit 0 of `stat_rd` is the powered-down flag and bit 1 is the acknowledge bit.
  - The flag is set by a stop1 wake and survives the reset hold.
  - `ack_wr` with `ack_data` = 1 clears it. A set in the same cycle wins over the clear.
  - `ack_data` = 0 has no effect.
  - Bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| stop_en | input | 1 | Stop modes permitted |
| mode_sel | input | 2 | Stop mode choice: 01 stop1, 10 stop2, 11 stop3 |
| dbg_en | input | 1 | Keep the debug clock running in stop |
| adc_stop_on | input | 1 | Keep the ADC powered in stop3 |
| clkgen_stop_on | input | 1 | Keep the clock generator powered in stop3 |
| wake_pin_n | input | 1 | Asynchronous wake pin, active low |
| wake_pu_en | input | 1 | Pull-up enable for the wake pin |
| rti_wake | input | 1 | Periodic interrupt wake request |
| rti_en | input | 1 | Periodic interrupt enable |
| vdd_low | input | 1 | Supply below threshold |
| ack_wr | input | 1 | Write strobe to the acknowledge bit |
| ack_data | input | 1 | Value written to the acknowledge bit |
| pwr_on | output | 8 | Per-domain power enable |
| stby | output | 8 | Per-domain standby enable |
| periph_clk_en | output | 1 | Peripheral clock gate |
| dbg_clk_en | output | 1 | Debug clock gate |
| io_force_rst | output | 1 | Force all pins to their reset state |
| sys_rst | output | 1 | System reset output |
| in_stop | output | 1 | A stop mode is active |
| wake_pullup | output | 1 | Wake pin pull-up control |
| stat_rd | output | 2 | Status read: bit 0 powered-down flag, bit 1 acknowledge (reads 0) |

## Verification
The bench keeps its own cycle model and compares it against the design at every clock, so the corner cases below are checked in the exact cycle they should occur.
- A wake pulse only one cycle long must still wake the block. A synchroniser tap taken one stage too early, or too late, moves the wake by a cycle and the comparison catches it.
- A stop request made while the pin is already low must wake the block at once. So must the interrupt, but only while its enable is set.
- The supply-low input is raised in the middle of a stop1 recovery. A counter that fails to restart, or a hold that ignores the supply, releases `sys_rst` early.
- An acknowledge is written in the same cycle as a stop1 wake, and a write of 0 is issued. Wrong priority between set and clear, or a clear on any write, shows up on `stat_rd`.
- Illegal requests are issued with stop disabled and with mode 00. The bench checks that they reset the system without raising the flag.

// File: rtl/lpstop_pkg.sv
`timescale 1ns/1ps
package lpstop_pkg;

    localparam int NUM_DOM    = 8;
    localparam int DOM_CPU    = 0;
    localparam int DOM_RAM    = 1;
    localparam int DOM_FLASH  = 2;
    localparam int DOM_PORT   = 3;
    localparam int DOM_ADC    = 4;
    localparam int DOM_CMP    = 5;
    localparam int DOM_CLKGEN = 6;
    localparam int DOM_SBUS   = 7;

    // domains kept in standby in the intermediate mode
    localparam logic [NUM_DOM-1:0] S2_STBY_MASK = NUM_DOM'(1) << DOM_RAM;
    // domains whose power in the light mode follows their own enable
    localparam logic [NUM_DOM-1:0] S3_KEEP_MASK =
        (NUM_DOM'(1) << DOM_ADC) | (NUM_DOM'(1) << DOM_CLKGEN);
    localparam logic [NUM_DOM-1:0] S3_STBY_MASK = ~S3_KEEP_MASK;

    localparam logic [1:0] SEL_NONE  = 2'b00;
    localparam logic [1:0] SEL_STOP1 = 2'b01;
    localparam logic [1:0] SEL_STOP2 = 2'b10;
    localparam logic [1:0] SEL_STOP3 = 2'b11;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_STOP1,
        ST_STOP2,
        ST_STOP3,
        ST_RSTHOLD
    } pm_state_e;

    function automatic pm_state_e sel_to_state(input logic [1:0] sel);
        pm_state_e s;
        case (sel)
            SEL_STOP1: s = ST_STOP1;
            SEL_STOP2: s = ST_STOP2;
            default:   s = ST_STOP3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lpstop_wake_sync.sv
`timescale 1ns/1ps
module lpstop_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
        end
    end

    assign pin_low = ~chain_q[STAGES-1];

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_q[STAGES-2] |=> pin_low); // R7

endmodule

// File: rtl/lpstop_pdflag.sv
`timescale 1ns/1ps
module lpstop_pdflag (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       ack_wr_i,
    input  logic       ack_data_i,
    output logic       flag_o,
    output logic [1:0] stat_o
);

    logic flag_q;
    logic clr;

    assign clr = ack_wr_i && ack_data_i;

    // only a true power-on reset clears it; the system reset output does not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign stat_o = {1'b0, flag_q};

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(ack_wr_i && ack_data_i)) |=> flag_o); // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_i && ack_data_i && !set_i) |=> !flag_o); // R11

endmodule

// File: rtl/lpstop_domain_map.sv
`timescale 1ns/1ps
module lpstop_domain_map
    import lpstop_pkg::*;
(
    input  pm_state_e            state_i,
    input  logic [NUM_DOM-1:0]   keep_en_i,
    output logic [NUM_DOM-1:0]   pwr_on_o,
    output logic [NUM_DOM-1:0]   stby_o
);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic p;
        logic s;

        always_comb begin
            p = 1'b0;
            s = 1'b0;
            unique case (state_i)
                ST_RUN, ST_RSTHOLD: p = 1'b1;
                ST_STOP1:           p = 1'b0;
                ST_STOP2:           s = S2_STBY_MASK[d];
                ST_STOP3: begin
                    s = S3_STBY_MASK[d];
                    p = S3_KEEP_MASK[d] & keep_en_i[d];
                end
                default:            p = 1'b0;
            endcase
        end

        assign pwr_on_o[d] = p;
        assign stby_o[d]   = s;
    end

endmodule

// File: rtl/lpstop_fsm.sv
`timescale 1ns/1ps
module lpstop_fsm
    import lpstop_pkg::*;
#(
    parameter int RST_CYCLES    = 4,
    parameter bit ILLEGAL_RESET = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       stop_en,
    input  logic [1:0] mode_sel,
    input  logic       wake_req,
    input  logic       vdd_low,
    input  logic       dbg_en,
    input  logic       wake_pu_en,
    output pm_state_e  state_o,
    output logic       s1_wake_o,
    output logic       periph_clk_en,
    output logic       dbg_clk_en,
    output logic       io_force_rst,
    output logic       sys_rst,
    output logic       in_stop,
    output logic       wake_pullup
);

    localparam int            CW       = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

    pm_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          req_legal;

    assign req_legal = stop_en && (mode_sel != SEL_NONE);

    // next state and hold counter
    always_comb begin
        state_d   = state_q;
        cnt_d     = '0;
        s1_wake_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) begin
                    if (req_legal) begin
                        state_d = sel_to_state(mode_sel);
                    end else if (ILLEGAL_RESET) begin
                        state_d = ST_RSTHOLD;
                    end
                end
            end
            ST_STOP1: begin
                if (wake_req) begin
                    state_d   = ST_RSTHOLD;
                    s1_wake_o = 1'b1;
                end
            end
            ST_STOP2, ST_STOP3: begin
                if (wake_req) begin
                    state_d = ST_RUN;
                end
            end
            ST_RSTHOLD: begin
                if (vdd_low) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = ST_RSTHOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RSTHOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        periph_clk_en = 1'b0;
        dbg_clk_en    = 1'b0;
        io_force_rst  = 1'b0;
        sys_rst       = 1'b0;
        in_stop       = 1'b0;
        wake_pullup   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                periph_clk_en = 1'b1;
                dbg_clk_en    = 1'b1;
            end
            ST_STOP1: begin
                io_force_rst = 1'b1;
                in_stop      = 1'b1;
                dbg_clk_en   = dbg_en;
                wake_pullup  = wake_pu_en;
            end
            ST_STOP2, ST_STOP3: begin
                in_stop     = 1'b1;
                dbg_clk_en  = dbg_en;
                wake_pullup = wake_pu_en;
            end
            ST_RSTHOLD: begin
                periph_clk_en = 1'b1;
                dbg_clk_en    = 1'b1;
                io_force_rst  = 1'b1;
                sys_rst       = 1'b1;
            end
            default: sys_rst = 1'b1;
        endcase
    end

    assign state_o = state_q;

    AST_DEEP_WAKE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP1 && wake_req) |=> (state_q == ST_RSTHOLD)); // R9
    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RSTHOLD && vdd_low) |=> (state_q == ST_RSTHOLD)); // R9
    AST_LIGHT_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STOP2 || state_q == ST_STOP3) && wake_req) |=> (state_q == ST_RUN)); // R10
    AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STOP1 || state_q == ST_STOP2 || state_q == ST_STOP3) && !wake_req)
        |=> $stable(state_q)); // R7

endmodule

// File: rtl/lpstop_ctrl.sv
`timescale 1ns/1ps
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int RST_CYCLES    = 4,
    parameter bit ILLEGAL_RESET = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic               stop_en,
    input  logic [1:0]         mode_sel,
    input  logic               dbg_en,
    input  logic               adc_stop_on,
    input  logic               clkgen_stop_on,
    input  logic               wake_pin_n,
    input  logic               wake_pu_en,
    input  logic               rti_wake,
    input  logic               rti_en,
    input  logic               vdd_low,
    input  logic               ack_wr,
    input  logic               ack_data,
    output logic [NUM_DOM-1:0] pwr_on,
    output logic [NUM_DOM-1:0] stby,
    output logic               periph_clk_en,
    output logic               dbg_clk_en,
    output logic               io_force_rst,
    output logic               sys_rst,
    output logic               in_stop,
    output logic               wake_pullup,
    output logic [1:0]         stat_rd
);

    logic               pin_low;
    logic               wake_req;
    logic               s1_wake;
    logic               pd_flag;
    logic [NUM_DOM-1:0] keep_en;
    pm_state_e          state;

    lpstop_wake_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (wake_pin_n),
        .pin_low (pin_low)
    );

    assign wake_req = pin_low | (rti_wake & rti_en);

    lpstop_fsm #(
        .RST_CYCLES    (RST_CYCLES),
        .ILLEGAL_RESET (ILLEGAL_RESET)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .stop_en       (stop_en),
        .mode_sel      (mode_sel),
        .wake_req      (wake_req),
        .vdd_low       (vdd_low),
        .dbg_en        (dbg_en),
        .wake_pu_en    (wake_pu_en),
        .state_o       (state),
        .s1_wake_o     (s1_wake),
        .periph_clk_en (periph_clk_en),
        .dbg_clk_en    (dbg_clk_en),
        .io_force_rst  (io_force_rst),
        .sys_rst       (sys_rst),
        .in_stop       (in_stop),
        .wake_pullup   (wake_pullup)
    );

    always_comb begin
        keep_en             = '0;
        keep_en[DOM_ADC]    = adc_stop_on;
        keep_en[DOM_CLKGEN] = clkgen_stop_on;
    end

    lpstop_domain_map u_dom (
        .state_i   (state),
        .keep_en_i (keep_en),
        .pwr_on_o  (pwr_on),
        .stby_o    (stby)
    );

    lpstop_pdflag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (s1_wake),
        .ack_wr_i   (ack_wr),
        .ack_data_i (ack_data),
        .flag_o     (pd_flag),
        .stat_o     (stat_rd)
    );

    AST_STOP_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |-> !periph_clk_en); // R5
    AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP1) |-> (pwr_on == '0 && stby == '0)); // R4
    AST_MID_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP2) |-> (pwr_on == '0 && stby == S2_STBY_MASK)); // R4
    AST_LIGHT_WAKE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STOP2 || state == ST_STOP3) && wake_req) |=> $stable(pd_flag)); // R10

endmodule

// File: tb/lpstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpstop_ctrl_tb_top;

    localparam int RSTC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       stop_en = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       dbg_en = 1'b0;
    logic       adc_stop_on = 1'b0;
    logic       clkgen_stop_on = 1'b0;
    logic       wake_pin_n = 1'b1;
    logic       wake_pu_en = 1'b0;
    logic       rti_wake = 1'b0;
    logic       rti_en = 1'b0;
    logic       vdd_low = 1'b0;
    logic       ack_wr = 1'b0;
    logic       ack_data = 1'b0;

    logic [7:0] pwr_on;
    logic [7:0] stby;
    logic       periph_clk_en;
    logic       dbg_clk_en;
    logic       io_force_rst;
    logic       sys_rst;
    logic       in_stop;
    logic       wake_pullup;
    logic [1:0] stat_rd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model: 0 run, 1 stop1, 2 stop2, 3 stop3, 4 reset hold
    int m_st   = 4;
    int m_cnt  = 0;
    int m_flag = 0;
    int m_pin[$] = '{1, 1};

    always #2.5 clk = ~clk;

    lpstop_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .stop_req       (stop_req),
        .stop_en        (stop_en),
        .mode_sel       (mode_sel),
        .dbg_en         (dbg_en),
        .adc_stop_on    (adc_stop_on),
        .clkgen_stop_on (clkgen_stop_on),
        .wake_pin_n     (wake_pin_n),
        .wake_pu_en     (wake_pu_en),
        .rti_wake       (rti_wake),
        .rti_en         (rti_en),
        .vdd_low        (vdd_low),
        .ack_wr         (ack_wr),
        .ack_data       (ack_data),
        .pwr_on         (pwr_on),
        .stby           (stby),
        .periph_clk_en  (periph_clk_en),
        .dbg_clk_en     (dbg_clk_en),
        .io_force_rst   (io_force_rst),
        .sys_rst        (sys_rst),
        .in_stop        (in_stop),
        .wake_pullup    (wake_pullup),
        .stat_rd        (stat_rd)
    );

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 4; m_cnt = 0; m_flag = 0;
            m_pin = '{1, 1};
        end else begin
            bit wake;
            bit set_f;
            wake  = (m_pin[0] == 0) || (rti_wake && rti_en);
            set_f = 1'b0;
            if (m_st == 0) begin
                if (stop_req) begin
                    if (stop_en && mode_sel != 2'b00) m_st = int'(mode_sel);
                    else m_st = 4;
                end
            end else if (m_st == 1) begin
                if (wake) begin m_st = 4; m_cnt = 0; set_f = 1'b1; end
            end else if (m_st == 2 || m_st == 3) begin
                if (wake) m_st = 0;
            end else begin
                if (vdd_low) m_cnt = 0;
                else if (m_cnt == RSTC - 1) begin m_st = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if (set_f) m_flag = 1;
            else if (ack_wr && ack_data) m_flag = 0;
            void'(m_pin.pop_front());
            m_pin.push_back(int'(wake_pin_n));
        end
    end

    task automatic chk(input string what, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit e_run, e_hold, e_stop;
            logic [7:0] e_pwr, e_stby;
            e_run  = (m_st == 0);
            e_hold = (m_st == 4);
            e_stop = (m_st >= 1 && m_st <= 3);
            e_pwr  = (e_run || e_hold) ? 8'hFF :
                     (m_st == 3) ? {1'b0, clkgen_stop_on, 1'b0, adc_stop_on, 4'b0000} : 8'h00;
            e_stby = (m_st == 2) ? 8'h02 : (m_st == 3) ? 8'hAF : 8'h00;
            chk("sys_rst", "R1 R3 R9 R10", 32'(sys_rst), 32'(e_hold));
            chk("in_stop", "R2 R3 R7 R8 R10", 32'(in_stop), 32'(e_stop));
            chk("pwr_on", "R4", 32'(pwr_on), 32'(e_pwr));
            chk("stby", "R4", 32'(stby), 32'(e_stby));
            chk("periph_clk_en", "R5", 32'(periph_clk_en), 32'(!e_stop));
            chk("dbg_clk_en", "R5", 32'(dbg_clk_en), 32'(e_stop ? dbg_en : 1'b1));
            chk("io_force_rst", "R6", 32'(io_force_rst), 32'(m_st == 1 || e_hold));
            chk("wake_pullup", "R7", 32'(wake_pullup), 32'(e_stop && wake_pu_en));
            chk("stat_rd", "R11", 32'(stat_rd), 32'(m_flag));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        // R1: power-on hold, extended by a low supply (R9)
        tick(2);
        rst_n = 1'b1; vdd_low = 1'b1;
        tick(3);
        vdd_low = 1'b0;
        tick(6);

        // R2 R4: stop3, ADC kept, debug clock on; one-cycle pin pulse wakes (R7 R10)
        mode_sel = 2'b11; stop_en = 1'b1; dbg_en = 1'b1; adc_stop_on = 1'b1;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(4);
        wake_pin_n = 1'b0; tick(1); wake_pin_n = 1'b1;
        tick(4);

        // stop3 with clock generator kept; a request while stopped is ignored; R8 wake
        adc_stop_on = 1'b0; clkgen_stop_on = 1'b1; dbg_en = 1'b0;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(2);
        mode_sel = 2'b01; stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(2);
        rti_en = 1'b1; rti_wake = 1'b1; tick(1); rti_wake = 1'b0; rti_en = 1'b0;
        tick(3);

        // stop2: interrupt masked has no effect, then enabled wakes (R8)
        mode_sel = 2'b10; stop_req = 1'b1; tick(1); stop_req = 1'b0;
        rti_wake = 1'b1; tick(4);
        rti_en = 1'b1; tick(1);
        rti_wake = 1'b0; rti_en = 1'b0;
        tick(3);

        // stop1 with pull-up; ack while flag clear; pin wake, supply low during hold (R9 R11)
        wake_pu_en = 1'b1; mode_sel = 2'b01;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(3);
        ack_wr = 1'b1; ack_data = 1'b1; tick(1); ack_wr = 1'b0; ack_data = 1'b0;
        wake_pin_n = 1'b0; tick(3);
        vdd_low = 1'b1; tick(5);
        vdd_low = 1'b0; wake_pin_n = 1'b1;
        tick(8);

        // R11: write 0 keeps the flag, write 1 clears it
        ack_wr = 1'b1; ack_data = 1'b0; tick(1); ack_wr = 1'b0;
        tick(2);
        ack_wr = 1'b1; ack_data = 1'b1; tick(1); ack_wr = 1'b0; ack_data = 1'b0;
        tick(2);

        // R3: illegal requests
        stop_en = 1'b0; stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(8);
        stop_en = 1'b1; mode_sel = 2'b00; stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(8);

        // stop1 woken by interrupt with an ack in the same cycle: set wins (R11)
        mode_sel = 2'b01; wake_pu_en = 1'b0;
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(2);
        rti_en = 1'b1; rti_wake = 1'b1; ack_wr = 1'b1; ack_data = 1'b1;
        tick(1);
        rti_wake = 1'b0; rti_en = 1'b0; ack_wr = 1'b0; ack_data = 1'b0;
        tick(8);

        // R7: pin already low when stop2 is entered
        wake_pin_n = 1'b0; tick(3);
        mode_sel = 2'b10; stop_req = 1'b1; tick(1); stop_req = 1'b0;
        tick(4);
        wake_pin_n = 1'b1;
        tick(4);

        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule